// File: doc/BRIEF.md
# Dual-Edge Parallel Word Loader with Select Chaining

This block fills a bank of per-channel data registers from an 8-bit parallel bus. Every change of level on the shift clock input counts as one transfer, whether the clock rises or falls. The block stores one word per transfer while its select input is active. Words fill the channels in ascending order, starting at channel 1. The stored words are always visible on a wide read port, where downstream comparison logic can pick them up.

The block runs on a fast system clock. The shift clock, the select input and the data bus are all registered through the same synchronizer depth, so each data sample stays aligned with the clock sample it belongs to. Shift-clock transitions are found by comparing two consecutive synchronized samples.

Once the last channel holds a word, the block raises its select output. In a chain of devices, that output drives the select input of the next device, so loading moves on to it. Dropping the select input rearms the block for a new load, which starts again at channel 1.

Top module: `gs_byte_loader`

## Requirements
- R1: While reset is high and on the cycle after it, every stored word reads zero and the select output is low.
- R2: A rising transition of the shift clock, seen while the select input is high, stores the data bus value into the next free channel.
- R3: A falling transition of the shift clock, seen while the select input is high, also stores one word, so each full shift-clock period stores two words.
- R4: Words go to channels in arrival order: the first to channel 1, which is bits [7:0] of the read port, then channel 2 at bits [15:8], and so on. Channel k is found at bits [8k-1:8k-8].
- R5: The select output rises when the 32nd word is stored, which is after 32 transitions or 16 shift-clock periods. It stays low before that point.
- R6: While the select input is low, shift-clock transitions store nothing and every stored word keeps its value.
- R7: Once all channels are full, further transitions store nothing until the select input has been dropped and raised again.
- R8: Dropping the select input lowers the select output and returns the write position to channel 1. Stored words keep their values until they are overwritten.
- R9: Bus bit 7 is the most significant bit of each word and lands in bit 7 of its channel. Bus bit 0 lands in bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; must run well above twice the shift-clock transition rate |
| rst | input | 1 | Synchronous active-high reset |
| sclk_in | input | 1 | Shift clock; both transitions store a word |
| sel_in | input | 1 | Select input; high enables loading |
| data_in | input | 8 | Parallel data word, bit 7 most significant |
| sel_out | output | 1 | Select output to the next chained device; high once all channels are loaded |
| chan_words | output | 256 | All stored words, channel 1 in the lowest byte |

## Verification
The bench builds the block with its default parameters: 32 channels of 8 bits and a two-stage synchronizer. With these values the bench can drive a complete 32-transition load and observe the select output rising exactly at the last channel. It can also apply extra transitions to a full bank and confirm that nothing changes. The bench alternates rising and falling transitions with distinct data values, so it can tell a missed edge or a swapped channel from a correct load. It also reloads a few channels after a select drop and confirms that the untouched channels keep their earlier contents.

// File: rtl/gsl_pkg.sv
package gsl_pkg;

    localparam int unsigned GSL_DEF_CHANNELS = 32;
    localparam int unsigned GSL_DEF_WORD_W   = 8;
    localparam int unsigned GSL_DEF_SYNC     = 2;

    typedef enum logic [1:0] {
        EDGE_NONE = 2'b00,
        EDGE_RISE = 2'b01,
        EDGE_FALL = 2'b10
    } edge_kind_e;

    typedef struct packed {
        logic       active;
        edge_kind_e kind;
    } xfer_evt_t;

    function automatic int unsigned gsl_next_slot(input int unsigned cur,
                                                  input int unsigned last);
        return (cur >= last) ? cur : cur + 1;
    endfunction

    function automatic edge_kind_e gsl_classify(input logic prev, input logic now);
        case ({prev, now})
            2'b01:   return EDGE_RISE;
            2'b10:   return EDGE_FALL;
            default: return EDGE_NONE;
        endcase
    endfunction

endpackage

// File: rtl/gsl_front_sync.sv
module gsl_front_sync
    import gsl_pkg::*;
#(
    parameter int unsigned W      = GSL_DEF_WORD_W,
    parameter int unsigned STAGES = GSL_DEF_SYNC
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sclk_raw,
    input  logic             sel_raw,
    input  logic [W-1:0]     data_raw,
    output logic             sel_sync,
    output logic [W-1:0]     data_sync,
    output xfer_evt_t        evt
);
    localparam int unsigned LAST = STAGES - 1;

    logic [STAGES-1:0] sclk_pipe;
    logic [STAGES-1:0] sel_pipe;
    logic [W-1:0]      data_pipe [STAGES];
    logic              sclk_prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_pipe <= '0;
            sel_pipe  <= '0;
            sclk_prev <= 1'b0;
            for (int i = 0; i < STAGES; i++) data_pipe[i] <= '0;
        end else begin
            sclk_pipe[0] <= sclk_raw;
            sel_pipe[0]  <= sel_raw;
            data_pipe[0] <= data_raw;
            for (int i = 1; i < STAGES; i++) begin
                sclk_pipe[i] <= sclk_pipe[i-1];
                sel_pipe[i]  <= sel_pipe[i-1];
                data_pipe[i] <= data_pipe[i-1];
            end
            sclk_prev <= sclk_pipe[LAST];
        end
    end

    always_comb begin
        evt.kind   = gsl_classify(sclk_prev, sclk_pipe[LAST]);
        evt.active = (evt.kind != EDGE_NONE);
        sel_sync   = sel_pipe[LAST];
        data_sync  = data_pipe[LAST];
    end

endmodule

// File: rtl/gsl_load_ctrl.sv
module gsl_load_ctrl
    import gsl_pkg::*;
#(
    parameter int unsigned N_CH = GSL_DEF_CHANNELS,
    localparam int unsigned PW  = (N_CH > 1) ? $clog2(N_CH) : 1
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           sel_sync,
    input  xfer_evt_t      evt,
    output logic           wr_en,
    output logic [PW-1:0]  wr_ptr,
    output logic           full
);
    localparam int unsigned LAST_SLOT = N_CH - 1;

    logic at_last;

    always_comb begin
        at_last = (int'(wr_ptr) == int'(LAST_SLOT));
        wr_en   = evt.active && sel_sync && !full;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            full   <= 1'b0;
        end else if (!sel_sync) begin
            wr_ptr <= '0;
            full   <= 1'b0;
        end else if (wr_en) begin
            wr_ptr <= PW'(gsl_next_slot(int'(wr_ptr), LAST_SLOT));
            if (at_last) full <= 1'b1;
        end
    end

endmodule

// File: rtl/gsl_word_bank.sv
module gsl_word_bank
    import gsl_pkg::*;
#(
    parameter int unsigned N_CH = GSL_DEF_CHANNELS,
    parameter int unsigned W    = GSL_DEF_WORD_W,
    localparam int unsigned PW  = (N_CH > 1) ? $clog2(N_CH) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [PW-1:0]     wr_ptr,
    input  logic [W-1:0]      wr_data,
    output logic [N_CH*W-1:0] words
);
    for (genvar ch = 0; ch < N_CH; ch++) begin : g_ch
        logic [W-1:0] slot_q;
        logic         hit;

        assign hit = wr_en && (int'(wr_ptr) == ch);

        always_ff @(posedge clk) begin
            if (rst)      slot_q <= '0;
            else if (hit) slot_q <= wr_data;
        end

        assign words[ch*W +: W] = slot_q;
    end

endmodule

// File: rtl/gs_byte_loader.sv
module gs_byte_loader
    import gsl_pkg::*;
#(
    parameter int unsigned N_CH   = GSL_DEF_CHANNELS,
    parameter int unsigned W      = GSL_DEF_WORD_W,
    parameter int unsigned STAGES = GSL_DEF_SYNC,
    localparam int unsigned PW    = (N_CH > 1) ? $clog2(N_CH) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sclk_in,
    input  logic              sel_in,
    input  logic [W-1:0]      data_in,
    output logic              sel_out,
    output logic [N_CH*W-1:0] chan_words
);
    logic          sel_s;
    logic [W-1:0]  data_s;
    xfer_evt_t     evt_s;
    logic          wr_en;
    logic [PW-1:0] wr_ptr;
    logic          full;

    gsl_front_sync #(.W(W), .STAGES(STAGES)) u_front (
        .clk       (clk),
        .rst       (rst),
        .sclk_raw  (sclk_in),
        .sel_raw   (sel_in),
        .data_raw  (data_in),
        .sel_sync  (sel_s),
        .data_sync (data_s),
        .evt       (evt_s)
    );

    gsl_load_ctrl #(.N_CH(N_CH)) u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .sel_sync (sel_s),
        .evt      (evt_s),
        .wr_en    (wr_en),
        .wr_ptr   (wr_ptr),
        .full     (full)
    );

    gsl_word_bank #(.N_CH(N_CH), .W(W)) u_bank (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_ptr  (wr_ptr),
        .wr_data (data_s),
        .words   (chan_words)
    );

    assign sel_out = full;

endmodule

// File: rtl/gsl_checker.sv
module gsl_checker #(
    parameter int unsigned N_CH = 32,
    parameter int unsigned W    = 8,
    localparam int unsigned PW  = (N_CH > 1) ? $clog2(N_CH) : 1
) (
    input logic              clk,
    input logic              rst,
    input logic              sel_s,
    input logic              wr_en,
    input logic [PW-1:0]     wr_ptr,
    input logic              sel_out,
    input logic [N_CH*W-1:0] words
);
    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> (!sel_out && wr_ptr == '0 && words == '0));

    a_r4_ptr_steps: assert property (@(posedge clk) disable iff (rst)
        (wr_en && sel_s && int'(wr_ptr) != int'(N_CH - 1)) |=>
            (int'(wr_ptr) == int'($past(wr_ptr)) + 1));

    a_r5_full_raises_sel: assert property (@(posedge clk) disable iff (rst)
        (wr_en && int'(wr_ptr) == int'(N_CH - 1)) |=> sel_out);

    a_r6_idle_holds_words: assert property (@(posedge clk) disable iff (rst)
        !sel_s |=> $stable(words));

    a_r7_full_holds_words: assert property (@(posedge clk) disable iff (rst)
        sel_out |=> $stable(words));

    a_r8_drop_rearms: assert property (@(posedge clk) disable iff (rst)
        !sel_s |=> (!sel_out && wr_ptr == '0));

endmodule

bind gs_byte_loader gsl_checker #(.N_CH(N_CH), .W(W)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .sel_s   (sel_s),
    .wr_en   (wr_en),
    .wr_ptr  (wr_ptr),
    .sel_out (sel_out),
    .words   (chan_words)
);

// File: tb/gs_byte_loader_tb.sv
module gs_byte_loader_tb;
    localparam int N_CH = 32;
    localparam int W    = 8;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              sclk_in = 1'b0;
    logic              sel_in = 1'b0;
    logic [W-1:0]      data_in = '0;
    logic              sel_out;
    logic [N_CH*W-1:0] chan_words;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    always #10 clk = ~clk;

    gs_byte_loader u_dut (
        .clk        (clk),
        .rst        (rst),
        .sclk_in    (sclk_in),
        .sel_in     (sel_in),
        .data_in    (data_in),
        .sel_out    (sel_out),
        .chan_words (chan_words)
    );

    function automatic logic [7:0] pat_a(input int i);
        return 8'((i * 37 + 5) & 255);
    endfunction

    function automatic logic [7:0] pat_b(input int i);
        return 8'(((i * 11) ^ 8'hA5) & 255);
    endfunction

    function automatic logic [7:0] word_at(input int ch);
        return chan_words[ch*W +: W];
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic shift_word(input logic [7:0] b);
        @(negedge clk);
        data_in = b;
        sclk_in = ~sclk_in;
        repeat (6) @(negedge clk);
    endtask

    task automatic set_sel(input logic v);
        @(negedge clk);
        sel_in = v;
        repeat (5) @(negedge clk);
    endtask

    task automatic t_reset;
        rst = 1'b1;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(sel_out == 1'b0, "R1 sel_out after reset", int'(sel_out), 0);
        check(chan_words == '0, "R1 words cleared", int'(word_at(0)), 0);
    endtask

    task automatic t_first_edges;
        set_sel(1'b1);
        shift_word(pat_a(0));
        check(sclk_in == 1'b1, "R2 bench drove rising", int'(sclk_in), 1);
        check(word_at(0) == pat_a(0), "R2 rise stores ch1", int'(word_at(0)), int'(pat_a(0)));
        check(word_at(1) == 8'h00, "R4 ch2 still empty", int'(word_at(1)), 0);
        shift_word(pat_a(1));
        check(word_at(1) == pat_a(1), "R3 fall stores ch2", int'(word_at(1)), int'(pat_a(1)));
        check(word_at(0) == pat_a(0), "R4 ch1 kept", int'(word_at(0)), int'(pat_a(0)));
    endtask

    task automatic t_fill;
        for (int i = 2; i < N_CH - 1; i++) shift_word(pat_a(i));
        check(sel_out == 1'b0, "R5 sel_out low at 31 words", int'(sel_out), 0);
        shift_word(pat_a(N_CH - 1));
        check(sel_out == 1'b1, "R5 sel_out high at 32 words", int'(sel_out), 1);
        for (int i = 0; i < N_CH; i++)
            check(word_at(i) == pat_a(i), "R4 ascending order", int'(word_at(i)), int'(pat_a(i)));
    endtask

    task automatic t_ignore_full;
        shift_word(8'hEE);
        shift_word(8'hDD);
        check(word_at(0) == pat_a(0), "R7 ch1 untouched when full", int'(word_at(0)), int'(pat_a(0)));
        check(word_at(N_CH - 1) == pat_a(N_CH - 1), "R7 last untouched",
              int'(word_at(N_CH - 1)), int'(pat_a(N_CH - 1)));
        check(sel_out == 1'b1, "R7 sel_out stays high", int'(sel_out), 1);
    endtask

    task automatic t_sel_low;
        set_sel(1'b0);
        check(sel_out == 1'b0, "R8 sel drop clears sel_out", int'(sel_out), 0);
        for (int k = 0; k < 4; k++) shift_word(8'hFF);
        check(word_at(0) == pat_a(0), "R6 no store while deselected", int'(word_at(0)), int'(pat_a(0)));
        check(word_at(3) == pat_a(3), "R6 ch4 kept while deselected", int'(word_at(3)), int'(pat_a(3)));
    endtask

    task automatic t_reload;
        set_sel(1'b1);
        for (int i = 0; i < 3; i++) shift_word(pat_b(i));
        for (int i = 0; i < 3; i++)
            check(word_at(i) == pat_b(i), "R8 reload restarts at ch1", int'(word_at(i)), int'(pat_b(i)));
        check(word_at(3) == pat_a(3), "R8 later channels retained", int'(word_at(3)), int'(pat_a(3)));
        check(sel_out == 1'b0, "R8 sel_out low during reload", int'(sel_out), 0);
    endtask

    task automatic t_bit_order;
        shift_word(8'h80);
        check(word_at(3) == 8'h80, "R9 bus bit7 is MSB", int'(word_at(3)), 8'h80);
        shift_word(8'h01);
        check(word_at(4) == 8'h01, "R9 bus bit0 is LSB", int'(word_at(4)), 8'h01);
    endtask

    initial begin
        t_reset;
        t_first_edges;
        t_fill;
        t_ignore_full;
        t_sel_low;
        t_reload;
        t_bit_order;
        if (!done) begin
            done = 1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule